// File: doc/BRIEF.md
# MDIO Management Transaction Master

This block runs single register transactions on a two-wire PHY management bus, using Clause 22 framing. Software first loads a small configuration field that holds an enable bit and a clock divider. It then writes a command word that names the PHY, the register and the operation, and that carries a go bit. For a write, the 16-bit payload comes from a separate write-data register. For a read, the result arrives in a read-data register.

Each transaction sends one 64-bit frame. The frame is a run of ones as preamble, then the start code, the opcode, the two 5-bit addresses, a 2-bit turnaround and 16 data bits, most significant bit first. The master changes its output after MDC falls, and on a read it samples the line when MDC rises. The bus pull-up lives outside the block, so an address with no device answering reads back as 0xFFFF.

All register access uses plain write strobes with level readback. There is no valid/ready handshake and no back-pressure. Bit 7 of the command readback says whether a new command will be taken, and a command that arrives while that bit is low is dropped.

Top module: `mdio_master`

## Requirements
- R1: The configuration write keeps only bits 6:0. Bits 5:0 are the MDC divider and bit 6 is the enable. `cfg_rdata` returns those seven bits with zeros above them. While the enable is low, a go command starts no frame.
- R2: When the enable is set and the divider is zero, `cfg_err` is high, a go command starts no frame and MDC stays low.
- R3: The command word has this layout: PHY address in bits 28:24, register address in bits 20:16, opcode in bits 15:14, go bit in bit 11. A command with bit 11 clear starts nothing.
- R4: Opcode 1 sends a write frame, driven for all 64 bits. The frame is 32 ones, then 01, then 01, then the PHY address, the register address, turnaround 10 and the write-data register, every field MSB first. `mdio_o` changes only when MDC falls.
- R5: Opcode 2 sends a read frame whose opcode bits are 10. `mdio_oe` drops from bit 46 (the turnaround) to the end of the frame. The 16 data bits are sampled on the rising edges of MDC, and `rd_data` holds the result after the frame. `rd_data` changes only while a frame is running.
- R6: A read from an address where no device drives the line returns 0xFFFF.
- R7: A go command with opcode 0 or 3, received while idle, starts no frame and pulses `op_err` high for one cycle.
- R8: `cmd_rdata` bit 7 is the ready bit. It is low from the cycle after a go command is accepted until the frame ends. The other bits echo the stored command. While idle, MDC and `mdio_oe` are low.
- R9: Each MDC half period lasts divider+1 clocks. A frame is 64 MDC periods. The divider is captured when the frame starts, so a change during the frame has no effect on it.
- R10: A command written while busy is ignored: the frame in progress goes on unchanged and `cmd_rdata` keeps the stored command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write value (bits 6:0 kept) |
| cfg_rdata | output | 32 | Configuration readback |
| cfg_err | output | 1 | High when enabled with a zero divider |
| wd_we | input | 1 | Write-data register strobe |
| wd_wdata | input | 16 | Payload for write frames |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 32 | Command word |
| cmd_rdata | output | 32 | Stored command, bit 7 = ready |
| op_err | output | 1 | One-cycle pulse on a go with an invalid opcode |
| rd_data | output | 16 | Result of the last read frame |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data value driven toward the bus |
| mdio_oe | output | 1 | Drive enable for `mdio_o` |
| mdio_i | input | 1 | Bus value sampled by the master |

## Verification
A write frame to the highest PHY and register addresses shows that field order and bit order are correct right up to the edge of each field. A write followed by a read to the same responding device proves that the read sampling puts the bits in the right order. A read from an address with no responder, where only the pull-up answers, proves that the all-ones result comes from the bus and is not a stored value. Frames at two divider values, with the divider changed mid-frame, separate the per-cycle timing from the captured divider. Commands that are disabled, have a zero divider, have no go bit, carry a bad opcode or arrive while busy are each shown to leave the bus quiet.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  typedef enum logic [1:0] {
    MOP_RSV0  = 2'b00,
    MOP_WRITE = 2'b01,
    MOP_READ  = 2'b10,
    MOP_RSV3  = 2'b11
  } mdio_op_e;

  localparam int unsigned ADDR_W      = 5;
  localparam int unsigned DATA_W      = 16;
  localparam int unsigned CMD_PHY_LSB = 24;
  localparam int unsigned CMD_REG_LSB = 16;
  localparam int unsigned CMD_OP_LSB  = 14;
  localparam int unsigned CMD_GO_BIT  = 11;
  localparam int unsigned CMD_RDY_BIT = 7;

  localparam logic [1:0] SOF_CODE = 2'b01;
  localparam logic [1:0] TA_WRITE = 2'b10;
  localparam logic [1:0] TA_READ  = 2'b11;

  function automatic logic op_is_valid(input mdio_op_e op);
    return (op == MOP_WRITE) || (op == MOP_READ);
  endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int unsigned DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  // one tick every div+1 clocks while running
  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq #(
  parameter int unsigned FRAME_W  = 64,
  parameter int unsigned TA_IDX   = 46,
  parameter int unsigned DATA_IDX = 48,
  parameter int unsigned DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [FRAME_W-1:0] frame,
  input  logic              is_read,
  input  logic              tick,
  input  logic              mdio_i,
  output logic              busy,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              rd_load,
  output logic [DATA_W-1:0] rd_word
);

  localparam int unsigned IDX_W = $clog2(FRAME_W);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(FRAME_W - 1);
  localparam logic [IDX_W-1:0] TA_POS    = IDX_W'(TA_IDX);
  localparam logic [IDX_W-1:0] DATA_POS  = IDX_W'(DATA_IDX);

  logic               busy_q;
  logic               mdc_q;
  logic               rd_mode_q;
  logic               load_q;
  logic [IDX_W-1:0]   idx_q;
  logic [FRAME_W-1:0] sh_q;
  logic [DATA_W-1:0]  cap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      mdc_q     <= 1'b0;
      rd_mode_q <= 1'b0;
      load_q    <= 1'b0;
      idx_q     <= '0;
      sh_q      <= '1;
      cap_q     <= '0;
    end else begin
      load_q <= 1'b0;
      if (start && !busy_q) begin
        busy_q    <= 1'b1;
        mdc_q     <= 1'b0;
        rd_mode_q <= is_read;
        idx_q     <= '0;
        sh_q      <= frame;
      end else if (busy_q && tick) begin
        mdc_q <= ~mdc_q;
        if (!mdc_q) begin
          // rising MDC: capture read data
          if (rd_mode_q && (idx_q >= DATA_POS)) begin
            cap_q <= {cap_q[DATA_W-2:0], mdio_i};
          end
          if (rd_mode_q && (idx_q == LAST_IDX)) begin
            load_q <= 1'b1;
          end
        end else begin
          // falling MDC: next bit or end of frame
          if (idx_q == LAST_IDX) begin
            busy_q <= 1'b0;
          end else begin
            idx_q <= idx_q + 1'b1;
            sh_q  <= {sh_q[FRAME_W-2:0], 1'b1};
          end
        end
      end
    end
  end

  assign busy    = busy_q;
  assign mdc     = mdc_q;
  assign mdio_o  = busy_q ? sh_q[FRAME_W-1] : 1'b1;
  assign mdio_oe = busy_q && !(rd_mode_q && (idx_q >= TA_POS));
  assign rd_load = load_q;
  assign rd_word = cap_q;

endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int unsigned DIV_W   = 6,
  parameter int unsigned PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        cfg_err,
  input  logic        wd_we,
  input  logic [15:0] wd_wdata,
  input  logic        cmd_we,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] cmd_rdata,
  output logic        op_err,
  output logic [15:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  import mdio_pkg::*;

  localparam int unsigned CFG_W    = DIV_W + 1;
  localparam int unsigned HDR_W    = 2 + 2 + 2 * ADDR_W;
  localparam int unsigned TA_IDX   = PRE_LEN + HDR_W;
  localparam int unsigned DATA_IDX = TA_IDX + 2;
  localparam int unsigned FRAME_W  = DATA_IDX + DATA_W;

  logic [CFG_W-1:0]  cfg_q;
  logic [DATA_W-1:0] wd_q;
  logic [31:0]       cmd_q;
  logic              op_err_q;
  logic [DATA_W-1:0] rd_q;
  logic [DIV_W-1:0]  div_lat_q;

  logic              en;
  logic [DIV_W-1:0]  div;
  logic              clk_ok;
  logic              busy;
  logic              tick;
  logic              start;
  logic              go_req;
  logic              rd_load;
  logic [DATA_W-1:0] rd_word;
  mdio_op_e          cmd_op;
  logic [ADDR_W-1:0] cmd_phy;
  logic [ADDR_W-1:0] cmd_reg;
  logic [1:0]        ta_bits;
  logic [DATA_W-1:0] payload;
  logic [FRAME_W-1:0] frame_d;

  assign en     = cfg_q[DIV_W];
  assign div    = cfg_q[DIV_W-1:0];
  assign clk_ok = en && (div != '0);

  assign cmd_op  = mdio_op_e'(cmd_wdata[CMD_OP_LSB +: 2]);
  assign cmd_phy = cmd_wdata[CMD_PHY_LSB +: ADDR_W];
  assign cmd_reg = cmd_wdata[CMD_REG_LSB +: ADDR_W];
  assign go_req  = cmd_we && cmd_wdata[CMD_GO_BIT];
  assign start   = go_req && !busy && op_is_valid(cmd_op) && clk_ok;

  assign ta_bits = (cmd_op == MOP_READ) ? TA_READ : TA_WRITE;
  assign payload = (cmd_op == MOP_READ) ? '1 : wd_q;
  assign frame_d = {{PRE_LEN{1'b1}}, SOF_CODE, cmd_op, cmd_phy, cmd_reg, ta_bits, payload};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      wd_q      <= '0;
      cmd_q     <= '0;
      op_err_q  <= 1'b0;
      rd_q      <= '0;
      div_lat_q <= '0;
    end else begin
      if (cfg_we) cfg_q <= cfg_wdata[CFG_W-1:0];
      if (wd_we)  wd_q  <= wd_wdata;
      if (cmd_we && !busy) cmd_q <= cmd_wdata;
      op_err_q <= go_req && !busy && !op_is_valid(cmd_op);
      if (start)   div_lat_q <= div;
      if (rd_load) rd_q      <= rd_word;
    end
  end

  mdio_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .div   (div_lat_q),
    .tick  (tick)
  );

  mdio_frame_seq #(
    .FRAME_W  (FRAME_W),
    .TA_IDX   (TA_IDX),
    .DATA_IDX (DATA_IDX),
    .DATA_W   (DATA_W)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .frame   (frame_d),
    .is_read (cmd_op == MOP_READ),
    .tick    (tick),
    .mdio_i  (mdio_i),
    .busy    (busy),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .rd_load (rd_load),
    .rd_word (rd_word)
  );

  assign cfg_rdata = {{(32 - CFG_W){1'b0}}, cfg_q};
  assign cfg_err   = en && (div == '0);
  assign cmd_rdata = {cmd_q[31:CMD_RDY_BIT+1], ~busy, cmd_q[CMD_RDY_BIT-1:0]};
  assign op_err    = op_err_q;
  assign rd_data   = rd_q;

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int unsigned DIV_W = 6
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] cfg_rdata,
  input logic        cfg_err,
  input logic        cmd_we,
  input logic [31:0] cmd_wdata,
  input logic [31:0] cmd_rdata,
  input logic        op_err,
  input logic [15:0] rd_data,
  input logic        mdc,
  input logic        mdio_oe
);

  logic ready;
  logic go;
  logic bad_op;
  logic clk_ok;

  assign ready  = cmd_rdata[7];
  assign go     = cmd_we && cmd_wdata[11];
  assign bad_op = (cmd_wdata[15:14] == 2'b00) || (cmd_wdata[15:14] == 2'b11);
  assign clk_ok = cfg_rdata[DIV_W] && (cfg_rdata[DIV_W-1:0] != '0);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!mdc && !mdio_oe)); // R8

  AST_DIV_ZERO_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && ready) |=> ready); // R2

  AST_BUSY_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && cmd_we) |=> $stable(cmd_rdata[31:8])); // R10

  AST_BAD_OP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && go && bad_op) |=> (op_err && ready)); // R7

  AST_RDDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> $stable(rd_data)); // R5

  AST_GO_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && go && !bad_op && clk_ok) |=> !ready); // R8

endmodule

bind mdio_master mdio_master_chk #(.DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_rdata (cfg_rdata),
  .cfg_err   (cfg_err),
  .cmd_we    (cmd_we),
  .cmd_wdata (cmd_wdata),
  .cmd_rdata (cmd_rdata),
  .op_err    (op_err),
  .rd_data   (rd_data),
  .mdc       (mdc),
  .mdio_oe   (mdio_oe)
);

// File: tb/mdio_master_test.sv
`timescale 1ns/1ps
module mdio_master_test;

  localparam logic [4:0] PHY_ADR = 5'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cfg_err;
  logic        wd_we = 1'b0;
  logic [15:0] wd_wdata = '0;
  logic        cmd_we = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] cmd_rdata;
  logic        op_err;
  logic [15:0] rd_data;
  logic        mdc;
  logic        mdio_o;
  logic        mdio_oe;
  logic        mdio_line;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mdio_master uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
    .wd_we(wd_we), .wd_wdata(wd_wdata),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata), .op_err(op_err),
    .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_line)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural PHY on the bus (pull-up when nobody drives)
  logic        phy_drv = 1'b0;
  logic        phy_bit = 1'b1;
  logic        rdy;
  int          phy_n = 0;
  logic [63:0] phy_cap = '0;
  logic        phy_rd_hit = 1'b0;
  logic [15:0] phy_rd_val = '0;
  logic [15:0] phy_mem [32];
  logic [31:0] phy_wmask = '0;

  assign rdy       = cmd_rdata[7];
  assign mdio_line = mdio_oe ? mdio_o : (phy_drv ? phy_bit : 1'b1);

  function automatic logic [15:0] phy_init(input logic [4:0] r);
    return 16'h5A00 ^ {3'b000, r, 3'b010, r};
  endfunction

  always @(posedge mdc or posedge rdy) begin
    if (rdy) begin
      phy_n <= 0;
      phy_rd_hit <= 1'b0;
    end else begin
      logic [63:0] full;
      logic [13:0] hdr;
      full = {phy_cap[62:0], mdio_line};
      phy_cap <= full;
      phy_n <= phy_n + 1;
      if (phy_n == 45) begin
        hdr = full[13:0];
        phy_rd_hit <= (hdr[13:12] == 2'b01) && (hdr[11:10] == 2'b10) && (hdr[9:5] == PHY_ADR);
        phy_rd_val <= phy_wmask[hdr[4:0]] ? phy_mem[hdr[4:0]] : phy_init(hdr[4:0]);
      end
      if (phy_n == 63 && full[31:30] == 2'b01 && full[29:28] == 2'b01 && full[27:23] == PHY_ADR) begin
        phy_mem[full[22:18]] <= full[15:0];
        phy_wmask[full[22:18]] <= 1'b1;
      end
    end
  end

  always @(negedge mdc or posedge rdy) begin
    if (rdy) begin
      phy_drv <= 1'b0;
    end else if (phy_n >= 48 && phy_n <= 63 && phy_rd_hit) begin
      phy_drv <= 1'b1;
      phy_bit <= phy_rd_val[63 - phy_n];
    end else begin
      phy_drv <= 1'b0;
    end
  end

  // ---------------- cycle reference model, compared after every edge
  bit          go = 1'b0;
  logic [31:0] go_word = '0;
  logic [6:0]  m_cfg = '0;
  logic [15:0] m_wd = '0;
  bit          m_active = 1'b0;
  int          m_t = 0;
  int          m_div = 1;
  bit          m_read = 1'b0;
  logic [63:0] m_frame = '0;

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      bit was, e_err, e_mdc, e_oe;
      int k;
      logic [1:0] op;
      was = m_active;
      e_err = 1'b0;
      if (was) begin
        m_t++;
        if (m_t / (m_div + 1) >= 128) m_active = 1'b0;
      end
      op = go_word[15:14];
      if (go && !was && go_word[11]) begin
        if (op == 2'b01 || op == 2'b10) begin
          if (m_cfg[6] && m_cfg[5:0] != 0) begin
            m_active = 1'b1;
            m_t = 0;
            m_div = int'(m_cfg[5:0]);
            m_read = (op == 2'b10);
            m_frame = {32'hFFFF_FFFF, 2'b01, op, go_word[28:24], go_word[20:16],
                       (op == 2'b10) ? 2'b11 : 2'b10, (op == 2'b10) ? 16'hFFFF : m_wd};
          end
        end else begin
          e_err = 1'b1;
        end
      end
      k = m_t / (m_div + 1);
      e_mdc = m_active ? k[0] : 1'b0;
      e_oe  = m_active && !(m_read && (k / 2) >= 46);
      chk(mdc == e_mdc, "R9 mdc", 32'(mdc), 32'(e_mdc));
      chk(mdio_oe == e_oe, "R5 mdio_oe", 32'(mdio_oe), 32'(e_oe));
      if (e_oe) chk(mdio_o == m_frame[63 - k / 2], "R4 mdio_o", 32'(mdio_o), 32'(m_frame[63 - k / 2]));
      chk(cmd_rdata[7] == !m_active, "R8 ready", 32'(cmd_rdata[7]), 32'(!m_active));
      chk(op_err == e_err, "R7 op_err", 32'(op_err), 32'(e_err));
      chk(cfg_err == (m_cfg[6] && m_cfg[5:0] == 0), "R2 cfg_err", 32'(cfg_err),
          32'(m_cfg[6] && m_cfg[5:0] == 0));
    end
  end

  // ---------------- stimulus tasks
  task automatic wr_cfg(input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v; m_cfg = v[6:0];
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr_wd(input logic [15:0] v);
    @(negedge clk);
    wd_we = 1'b1; wd_wdata = v; m_wd = v;
    @(negedge clk);
    wd_we = 1'b0;
  endtask

  function automatic logic [31:0] mk_cmd(input logic [4:0] phy, input logic [4:0] r,
                                          input logic [1:0] op, input bit g);
    return (32'(phy) << 24) | (32'(r) << 16) | (32'(op) << 14) | (32'(g) << 11);
  endfunction

  task automatic issue(input logic [31:0] w);
    @(negedge clk);
    cmd_we = 1'b1; cmd_wdata = w; go = 1'b1; go_word = w;
    @(negedge clk);
    cmd_we = 1'b0; go = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_active) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 32'd0, 32'd1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(cfg_rdata == 32'h0, "R1 reset cfg", cfg_rdata, 32'h0);
    chk(cmd_rdata == 32'h80, "R8 reset cmd", cmd_rdata, 32'h80);
    chk(rd_data == 16'h0, "R5 reset rd_data", 32'(rd_data), 32'h0);

    // R1: only low 7 bits kept; disabled -> no frame
    wr_cfg(32'hFFFF_FF82);
    chk(cfg_rdata == 32'h02, "R1 cfg low7", cfg_rdata, 32'h02);
    issue(mk_cmd(5'd3, 5'd1, 2'b01, 1'b1));
    repeat (10) @(negedge clk);
    chk(cmd_rdata[7] == 1'b1 && mdc == 1'b0, "R1 disabled no frame", cmd_rdata, 32'h80);

    // R2: enabled with zero divider
    wr_cfg(32'h40);
    chk(cfg_err == 1'b1, "R2 cfg_err", 32'(cfg_err), 32'h1);
    issue(mk_cmd(5'd3, 5'd2, 2'b10, 1'b1));
    repeat (20) @(negedge clk);
    chk(cmd_rdata[7] == 1'b1 && mdc == 1'b0, "R2 no clock", cmd_rdata, 32'h80);

    // R4: write frame at field-boundary addresses (nobody listens)
    wr_cfg(32'h41);
    wr_wd(16'h8001);
    w = mk_cmd(5'd31, 5'd31, 2'b01, 1'b1);
    issue(w);
    wait_idle();
    chk(cmd_rdata == (w | 32'h80), "R8 cmd echo", cmd_rdata, w | 32'h80);

    // R4/R5: write then read back from responding PHY
    wr_wd(16'hA5C3);
    issue(mk_cmd(PHY_ADR, 5'd4, 2'b01, 1'b1));
    wait_idle();
    issue(mk_cmd(PHY_ADR, 5'd4, 2'b10, 1'b1));
    wait_idle();
    chk(rd_data == 16'hA5C3, "R5 read back", 32'(rd_data), 32'hA5C3);

    // R9/R10: read at divider 3, divider changed and command sent mid-frame
    wr_cfg(32'h43);
    w = mk_cmd(PHY_ADR, 5'd2, 2'b10, 1'b1);
    issue(w);
    repeat (40) @(negedge clk);
    wr_cfg(32'h45);
    wr_wd(16'h1234);
    issue(mk_cmd(5'd1, 5'd9, 2'b01, 1'b1));
    chk(cmd_rdata == w, "R10 busy cmd ignored", cmd_rdata, w);
    wait_idle();
    chk(rd_data == phy_init(5'd2), "R5 read init reg", 32'(rd_data), 32'(phy_init(5'd2)));
    chk(cmd_rdata == (w | 32'h80), "R10 cmd kept", cmd_rdata, w | 32'h80);

    // R6: absent device reads all ones
    wr_cfg(32'h42);
    issue(mk_cmd(5'd9, 5'd1, 2'b10, 1'b1));
    wait_idle();
    chk(rd_data == 16'hFFFF, "R6 absent PHY", 32'(rd_data), 32'hFFFF);

    // R7: invalid opcodes
    issue(mk_cmd(PHY_ADR, 5'd1, 2'b00, 1'b1));
    repeat (6) @(negedge clk);
    issue(mk_cmd(PHY_ADR, 5'd1, 2'b11, 1'b1));
    repeat (6) @(negedge clk);
    chk(cmd_rdata[7] == 1'b1 && rd_data == 16'hFFFF, "R7 no frame", cmd_rdata, 32'h80);

    // R3: no go bit
    w = mk_cmd(5'd2, 5'd7, 2'b01, 1'b0);
    issue(w);
    repeat (8) @(negedge clk);
    chk(cmd_rdata == (w | 32'h80), "R3 no go bit", cmd_rdata, w | 32'h80);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R3 bus quiet", {30'd0, mdc, mdio_oe}, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule